// File: doc/BRIEF.md
# Truth-table boolean operation unit

This unit carries out the boolean instruction group of a 36-bit processor. Each opcode in the group holds a 4-bit function field, and the unit uses that field directly as a truth table. Every result bit is the function bit picked out by the matching accumulator bit and operand bit. All sixteen two-input functions therefore come out of one lookup and need no per-operation decode.

The unit accepts an instruction on a one-cycle start strobe. It takes the opcode, the accumulator value, the memory operand and the effective address. One cycle later it presents a registered result with a valid pulse and write enables for the accumulator and for memory. The two low opcode bits choose one of four modes. The modes decide which operand is used and where the result is written. Fetch, effective-address calculation and the memory port sit outside the block.

Top module: `bool_unit`

## Requirements
- R1: While reset (rst_n low) is held, and in the first cycle after it is released, result is zero and valid, ac_we and mem_we are low.
- R2: A start is accepted when opcode[8:6] equals 3'b100. The cycle after an accepted start, valid is high for exactly one cycle. If no further start is accepted, valid is low again in the cycle after that.
- R3: The function field is opcode[5:2], called F. For an accepted start, each bit i of the next result equals F[{~b[i], ~a[i]}]. Here a is ac_in and b is the operand. In other words, both ones selects F[0], a=0 with b=1 selects F[1], a=1 with b=0 selects F[2], and both zeros selects F[3]. Examples: 0000 gives zero, 0001 gives AND, 0011 gives the operand, 0101 gives the accumulator, and 1001 gives equivalence.
- R4: When opcode[1:0] is 01 (immediate), the operand is {18 zero bits, ea} and mem_in is ignored. For the other modes the operand is mem_in.
- R5: With valid high, the enables follow the mode of the accepted instruction. Mode 00 and mode 01 raise ac_we only. Mode 10 raises mem_we only. Mode 11 raises both. Neither enable is high when valid is low.
- R6: A start with opcode[8:6] not equal to 3'b100 is ignored. No valid or enable follows, and result keeps its value.
- R7: Result keeps its value in every cycle without an accepted start.
- R8: Accepted starts on consecutive cycles each produce their own result, valid and enables in the cycle after their own start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that starts an instruction |
| opcode | input | 9 | Instruction opcode; bit 8 is the most significant |
| ac_in | input | 36 | Accumulator value |
| mem_in | input | 36 | Memory operand |
| ea | input | 18 | Effective address |
| result | output | 36 | Registered result |
| valid | output | 1 | Result produced this cycle |
| ac_we | output | 1 | Write result to the accumulator |
| mem_we | output | 1 | Write result to memory |

## Verification
Two things can land in the same cycle: the output of one instruction is presented, and the start of the next instruction is taken, possibly in a different mode or with an opcode from outside the group. The bench provokes this with a long run of starts on random cycles with random opcodes, operands and addresses. Some of these starts fall back to back, and some use opcodes outside the group directly after an accepted one. A behavioural model predicts result, valid and both enables for every cycle. Each output is compared at the falling edge, so an overlap that corrupts or drops either instruction shows up as a miscompare.

// File: rtl/bool_unit.sv
module bool_unit #(
  parameter int W   = 36,
  parameter int AW  = 18,
  parameter int OPW = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] opcode,
  input  logic [W-1:0]   ac_in,
  input  logic [W-1:0]   mem_in,
  input  logic [AW-1:0]  ea,
  output logic [W-1:0]   result,
  output logic           valid,
  output logic           ac_we,
  output logic           mem_we
);
  localparam int PAD = W - AW;

  logic [3:0]   func;
  logic [1:0]   mode;
  logic         accept;
  logic [W-1:0] operand;
  logic [W-1:0] next_res;

  assign func    = opcode[5:2];
  assign mode    = opcode[1:0];
  assign accept  = start && (opcode[OPW-1 -: 3] == 3'b100);
  assign operand = (mode == 2'b01) ? {{PAD{1'b0}}, ea} : mem_in;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign next_res[i] = func[{~operand[i], ~ac_in[i]}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      valid  <= 1'b0;
      ac_we  <= 1'b0;
      mem_we <= 1'b0;
    end else begin
      valid  <= accept;
      ac_we  <= accept && (mode != 2'b10);
      mem_we <= accept && mode[1];
      if (accept) result <= next_res;
    end
  end

  p_accept_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> valid);
  p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> (!valid && !ac_we && !mem_we));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(result));
  p_memonly_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == 2'b10) |=> (mem_we && !ac_we));
  p_setz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && func == 4'b0000) |=> (result == '0));
  p_imm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode == 2'b01 && func == 4'b0011) |=> (result == {{PAD{1'b0}}, $past(ea)}));
endmodule

// File: tb/sim_bool_unit.sv
module sim_bool_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [8:0]  opcode = '0;
  logic [35:0] ac_in = '0, mem_in = '0;
  logic [17:0] ea = '0;
  logic [35:0] result;
  logic        valid, ac_we, mem_we;

  int vectors = 0, miscompares = 0, cycles = 0;
  string cur_req = "R1";
  logic [35:0] e_res = '0;
  logic e_valid = 0, e_ac = 0, e_mem = 0;
  bit done = 0;

  bool_unit u0 (.clk, .rst_n, .start, .opcode, .ac_in, .mem_in, .ea,
                .result, .valid, .ac_we, .mem_we);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [35:0] model(logic [8:0] op, logic [35:0] a, logic [35:0] m, logic [17:0] e);
    logic [35:0] b, r;
    b = (op[1:0] == 2'd1) ? {18'd0, e} : m;
    for (int i = 0; i < 36; i++) begin
      int idx;
      idx = 3 - (2 * int'(b[i]) + int'(a[i]));
      r[i] = op[2 + idx];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      e_res = '0; e_valid = 0; e_ac = 0; e_mem = 0;
    end else if (start && opcode[8:6] == 3'b100) begin
      e_res   = model(opcode, ac_in, mem_in, ea);
      e_valid = 1;
      e_ac    = (opcode[1:0] == 2'd0) || (opcode[1:0] == 2'd1) || (opcode[1:0] == 2'd3);
      e_mem   = (opcode[1:0] >= 2'd2);
    end else begin
      e_valid = 0; e_ac = 0; e_mem = 0;
    end
  end

  always @(negedge clk) if (!done) begin
    vectors++;
    if (result !== e_res) begin
      miscompares++;
      $display("FAIL %s result actual=%h expected=%h", cur_req, result, e_res);
    end
    if (valid !== e_valid) begin
      miscompares++;
      $display("FAIL %s R2 valid actual=%b expected=%b", cur_req, valid, e_valid);
    end
    if (ac_we !== e_ac || mem_we !== e_mem) begin
      miscompares++;
      $display("FAIL %s R5 ac_we/mem_we actual=%b%b expected=%b%b", cur_req, ac_we, mem_we, e_ac, e_mem);
    end
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d cycles expected<100000", cycles);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic op(logic [8:0] o, logic [35:0] a, logic [35:0] m, logic [17:0] e);
    @(negedge clk);
    #1 start = 1; opcode = o; ac_in = a; mem_in = m; ea = e;
    @(negedge clk);
    #1 start = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  localparam logic [35:0] A = 36'h0F0F_3C5A5, M = 36'h0033_99CC3;

  initial begin
    cur_req = "R1"; idle(4);
    @(negedge clk); #1 rst_n = 1;
    idle(1);
    cur_req = "R3";
    op(9'b100_0000_00, A, M, 18'h1);
    op(9'b100_0001_00, A, M, 18'h1);
    op(9'b100_0010_00, A, M, 18'h1);
    op(9'b100_0011_00, A, M, 18'h1);
    op(9'b100_0100_00, A, M, 18'h1);
    op(9'b100_0101_00, A, M, 18'h1);
    op(9'b100_1000_00, A, M, 18'h1);
    op(9'b100_1001_00, A, M, 18'h1);
    op(9'b100_1111_00, A, M, 18'h1);
    cur_req = "R4";
    op(9'b100_0011_01, A, M, 18'h2A5C3);
    op(9'b100_0001_01, '1, M, 18'h3FFFF);
    cur_req = "R5";
    op(9'b100_0110_10, A, M, 18'h0);
    op(9'b100_0111_11, A, M, 18'h0);
    cur_req = "R6";
    op(9'b101_0001_00, A, M, 18'h7);
    op(9'b000_1111_11, '1, '1, 18'h7);
    cur_req = "R7"; idle(3);
    cur_req = "R8";
    @(negedge clk);
    #1 start = 1; opcode = 9'b100_0001_00; ac_in = A; mem_in = M;
    @(negedge clk);
    #1 opcode = 9'b100_1001_10;
    @(negedge clk);
    #1 opcode = 9'b110_0000_00;
    @(negedge clk);
    #1 start = 0;
    idle(2);
    cur_req = "R8 random";
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      #1 start = ($urandom_range(0, 3) != 0);
      opcode = ($urandom_range(0, 3) != 0) ? {3'b100, 6'($urandom)} : 9'($urandom);
      ac_in = {4'($urandom), 32'($urandom)};
      mem_in = {4'($urandom), 32'($urandom)};
      ea = 18'($urandom);
    end
    @(negedge clk); #1 start = 0;
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule